// File: doc/BRIEF.md
# Start-of-Frame Tracker

This block follows the start-of-frame tokens that a USB host sends to a device once per millisecond. An upstream token decoder presents a one-cycle valid strobe together with the 11-bit frame number carried by the token. Each accepted token is captured into the frame register and raises a one-cycle interrupt pulse.

Alongside the capture path, two local cycle counters keep time. The first produces a local frame pulse on every nominal millisecond boundary, aligned to the most recent token. The second watches for a token that is overdue. It uses a window slightly longer than a millisecond (1.00358 ms). When the window runs out, it reports a lost frame and leaves the frame register untouched.

Tracking starts only when the first token arrives. A bus reset returns the block to its idle, untracked state. Both windows are derived in clock cycles from the clock frequency parameter, rounded up.

Top module: `sof_tracker`

## Requirements
- R1: After rst_ni is released, frame_o reads 0 and sof_irq_o, sof_lost_o and frame_tick_o are all 0.
- R2: A token is accepted when sof_valid_i is 1 and bus_reset_i is 0 at a clock edge. One cycle after that edge, frame_o holds the sampled sof_frame_i (11 bits, full range including the wrap from 0x7FF to 0x000).
- R3: An accepted token makes sof_irq_o high for exactly the one following cycle, and frame_tick_o is high in that same cycle.
- R4: frame_o changes only on an accepted token, on bus reset or on rst_ni. A lost frame leaves it unchanged.
- R5: Until the first token is accepted after reset or bus reset, sof_lost_o and frame_tick_o stay 0.
- R6: Once tracking, let T = ceil(CLK_HZ × 1.00358 ms) cycles. If no token is accepted at edges 1..T after the last accepted token or the last loss, sof_lost_o pulses for one cycle after edge T. A token accepted at edge T itself suppresses the loss, and consecutive losses repeat every T cycles.
- R7: Once tracking, frame_tick_o pulses every P = ceil(CLK_HZ × 1 ms) cycles, counted from the last accepted token. A token restarts this phase, and a token landing on a boundary gives one pulse, not two. A loss does not move the phase.
- R8: bus_reset_i clears frame_o, stops both timers and ends tracking. It takes priority over a token in the same cycle, which is then discarded without an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | Synchronous bus-reset indication, clears tracking |
| sof_valid_i | input | 1 | One-cycle strobe: a valid start-of-frame token was decoded |
| sof_frame_i | input | FRAME_W (11) | Frame number carried by the token |
| frame_o | output | FRAME_W (11) | Last captured frame number |
| sof_irq_o | output | 1 | One-cycle pulse per accepted token |
| sof_lost_o | output | 1 | One-cycle pulse per expired token window |
| frame_tick_o | output | 1 | Local frame pulse aligned to received tokens |

## Verification
The hardest situation to reach is the exact edge of the lost-token window: a token on cycle T must suppress the loss, while a token on cycle T+1 must arrive just after the loss pulse. The bench overrides the clock frequency to 1 MHz so that a window spans about a thousand cycles. It places each token on a counted negative edge relative to the previous one, so the acceptance edge is known exactly. Long silent stretches then produce back-to-back losses. A token sent at an arbitrary phase afterwards shows the local frame pulse realigning.

// File: rtl/sof_pkg.sv
package sof_pkg;

  localparam int unsigned SOF_FRAME_W = 11;

  // ceil(hz * ps / 1e12)
  function automatic int unsigned ps_to_cycles(longint unsigned hz, longint unsigned ps);
    longint unsigned prod;
    prod = hz * ps;
    return int'((prod + 64'd999_999_999_999) / 64'd1_000_000_000_000);
  endfunction

  typedef struct packed {
    logic irq;
    logic lost;
    logic tick;
  } sof_evt_t;

endpackage

// File: rtl/sof_cycle_timer.sv
module sof_cycle_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic restart_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || restart_i) cnt_q <= '0;
    else if (run_i)             cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sof_frame_latch.sv
module sof_frame_latch #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               take_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      irq_o   <= 1'b0;
    end else if (clr_i) begin
      frame_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= take_i;
      if (take_i) frame_o <= frame_i;
    end
  end
endmodule

// File: rtl/sof_tracker.sv
module sof_tracker
  import sof_pkg::*;
#(
  parameter int unsigned     CLK_HZ    = 50_000_000,
  parameter int unsigned     FRAME_W   = SOF_FRAME_W,
  parameter longint unsigned FRAME_PS  = 64'd1_000_000_000,
  parameter longint unsigned WINDOW_PS = 64'd1_003_580_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_reset_i,
  input  logic               sof_valid_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sof_irq_o,
  output logic               sof_lost_o,
  output logic               frame_tick_o
);
  localparam int unsigned PERIOD_CYC = ps_to_cycles(64'(CLK_HZ), FRAME_PS);
  localparam int unsigned WINDOW_CYC = ps_to_cycles(64'(CLK_HZ), WINDOW_PS);

  logic     sof_acc;
  logic     armed_q;
  logic     period_hit, window_hit;
  sof_evt_t evt_d, evt_q;

  assign sof_acc = sof_valid_i && !bus_reset_i;

  sof_frame_latch #(.FRAME_W(FRAME_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bus_reset_i),
    .take_i  (sof_acc),
    .frame_i (sof_frame_i),
    .frame_o (frame_o),
    .irq_o   (sof_irq_o)
  );

  // nominal frame phase; realigned by tokens only
  sof_cycle_timer #(.LIMIT(PERIOD_CYC)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bus_reset_i),
    .run_i     (armed_q),
    .restart_i (sof_acc),
    .hit_o     (period_hit)
  );

  // overdue window; self-restarts on expiry so each miss is reported
  sof_cycle_timer #(.LIMIT(WINDOW_CYC)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bus_reset_i),
    .run_i     (armed_q),
    .restart_i (sof_acc),
    .hit_o     (window_hit)
  );

  always_comb begin
    evt_d      = '0;
    evt_d.irq  = sof_acc;
    evt_d.lost = window_hit && !sof_acc && !bus_reset_i;
    evt_d.tick = sof_acc || (period_hit && !bus_reset_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      evt_q   <= '0;
    end else begin
      evt_q <= evt_d;
      if (bus_reset_i)  armed_q <= 1'b0;
      else if (sof_acc) armed_q <= 1'b1;
    end
  end

  assign sof_lost_o   = evt_q.lost;
  assign frame_tick_o = evt_q.tick;

endmodule

// File: rtl/sof_tracker_chk.sv
module sof_tracker_chk #(
  parameter int unsigned FRAME_W    = 11,
  parameter int unsigned WINDOW_CYC = 1000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_reset_i,
  input logic               sof_valid_i,
  input logic [FRAME_W-1:0] sof_frame_i,
  input logic [FRAME_W-1:0] frame_o,
  input logic               sof_irq_o,
  input logic               sof_lost_o,
  input logic               frame_tick_o
);
  localparam int unsigned GW = $clog2(WINDOW_CYC + 2);

  logic          seen_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (bus_reset_i) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      if (sof_irq_o) seen_q <= 1'b1;
      if (sof_irq_o || sof_lost_o)          gap_q <= GW'(1);
      else if (gap_q != GW'(WINDOW_CYC + 1)) gap_q <= gap_q + 1'b1;
    end
  end

  a_r2_frame_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_valid_i && !bus_reset_i) |=> (sof_irq_o && frame_o == $past(sof_frame_i)));

  a_r3_irq_with_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_irq_o |-> frame_tick_o);

  a_r4_frame_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_valid_i && !bus_reset_i) |=> $stable(frame_o));

  a_r5_quiet_untracked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !sof_irq_o) |-> (!sof_lost_o && !frame_tick_o));

  a_r6_loss_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_lost_o |-> (gap_q == GW'(WINDOW_CYC) && !sof_irq_o));

  a_r8_bus_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (frame_o == '0 && !sof_irq_o && !sof_lost_o && !frame_tick_o));

endmodule

bind sof_tracker sof_tracker_chk #(
  .FRAME_W    (FRAME_W),
  .WINDOW_CYC (WINDOW_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_reset_i  (bus_reset_i),
  .sof_valid_i  (sof_valid_i),
  .sof_frame_i  (sof_frame_i),
  .frame_o      (frame_o),
  .sof_irq_o    (sof_irq_o),
  .sof_lost_o   (sof_lost_o),
  .frame_tick_o (frame_tick_o)
);

// File: tb/tb_sof_tracker.sv
module tb_sof_tracker;
  // 1 MHz setting: P = ceil(1e6 * 1 ms) = 1000, T = ceil(1e6 * 1.00358 ms) = 1004
  localparam int P = 1000;
  localparam int T = 1004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        sof_valid = 1'b0;
  logic [10:0] sof_frame = '0;
  logic [10:0] frame;
  logic        irq, lost, tick;

  int checks = 0;
  int errors = 0;
  int lost_total = 0, tick_total = 0, irq_total = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sof_tracker #(.CLK_HZ(1_000_000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset),
    .sof_valid_i(sof_valid), .sof_frame_i(sof_frame),
    .frame_o(frame), .sof_irq_o(irq), .sof_lost_o(lost), .frame_tick_o(tick)
  );

  always @(posedge clk) begin
    lost_total <= lost_total + int'(lost);
    tick_total <= tick_total + int'(tick);
    irq_total  <= irq_total + int'(irq);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // call at a negedge; token sampled at the next posedge; returns one negedge later
  task automatic send_sof(input logic [10:0] f);
    sof_valid = 1'b1;
    sof_frame = f;
    @(negedge clk);
    sof_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(frame == 0, "R1 frame", frame, 0);
    check(!irq && !lost && !tick, "R1 pulses", {irq, lost, tick}, 0);
  endtask

  task automatic t_untracked;
    int lb = lost_total, tb = tick_total;
    idle(2500);
    check(lost_total == lb, "R5 no loss before first token", lost_total - lb, 0);
    check(tick_total == tb, "R5 no tick before first token", tick_total - tb, 0);
  endtask

  task automatic t_capture;
    send_sof(11'h5A3);
    check(frame == 11'h5A3, "R2 capture", frame, 11'h5A3);
    check(irq == 1'b1 && tick == 1'b1, "R3 irq+tick", {irq, tick}, 3);
    idle(1);
    check(irq == 1'b0 && tick == 1'b0, "R3 single cycle", {irq, tick}, 0);
  endtask

  task automatic t_nominal;
    logic [10:0] seq [5] = '{11'h7FE, 11'h7FF, 11'h000, 11'h001, 11'h002};
    int lb, tb, ib;
    idle(P - 2);
    lb = lost_total; tb = tick_total; ib = irq_total;
    foreach (seq[i]) begin
      send_sof(seq[i]);
      check(frame == seq[i], "R2 sequence", frame, seq[i]);
      idle(P - 1);
    end
    check(lost_total == lb, "R6 on-time tokens", lost_total - lb, 0);
    check(irq_total - ib == 5, "R3 irq count", irq_total - ib, 5);
    check(tick_total - tb == 5, "R7 one tick on boundary", tick_total - tb, 5);
  endtask

  task automatic t_window_edge;
    int lb;
    send_sof(11'h100);
    idle(T - 1);
    lb = lost_total;
    send_sof(11'h101);
    check(lost == 1'b0 && lost_total == lb, "R6 token at edge T", lost_total - lb, 0);
    check(frame == 11'h101, "R2 late-edge capture", frame, 11'h101);
    idle(T);
    check(lost == 1'b1, "R6 loss at T", lost, 1);
    check(frame == 11'h101, "R4 loss keeps frame", frame, 11'h101);
    send_sof(11'h102);
    check(frame == 11'h102, "R2 after loss", frame, 11'h102);
  endtask

  task automatic t_multi_loss;
    int lb, tb;
    send_sof(11'h200);
    lb = lost_total; tb = tick_total;
    idle(3 * T + 10);
    check(lost_total - lb == 3, "R6 repeated losses", lost_total - lb, 3);
    // token tick plus boundaries at P, 2P, 3P
    check(tick_total - tb == 4, "R7 free-running ticks", tick_total - tb, 4);
    check(frame == 11'h200, "R4 frame held", frame, 11'h200);
  endtask

  task automatic t_resync;
    int lb;
    idle(137);
    send_sof(11'h300);
    lb = lost_total;
    idle(P - 1);
    check(tick == 1'b0, "R7 no tick before P", tick, 0);
    idle(1);
    check(tick == 1'b1, "R7 realigned tick", tick, 1);
    idle(T - P - 1);
    check(lost_total == lb && !lost, "R6 window restarted", lost_total - lb, 0);
  endtask

  task automatic t_bus_reset;
    int lb, tb;
    send_sof(11'h444);
    idle(10);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    check(frame == 0, "R8 frame cleared", frame, 0);
    lb = lost_total; tb = tick_total;
    idle(2500);
    check(lost_total == lb && tick_total == tb, "R8 tracking stopped",
          lost_total - lb + tick_total - tb, 0);
    bus_reset = 1'b1;
    send_sof(11'h555);
    bus_reset = 1'b0;
    check(frame == 0 && !irq, "R8 priority over token", {irq, frame}, 0);
    tb = tick_total;
    idle(2500);
    check(tick_total == tb, "R5 still untracked", tick_total - tb, 0);
    send_sof(11'h0AB);
    check(irq && frame == 11'h0AB, "R2 rearm", frame, 11'h0AB);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_untracked();
    t_capture();
    t_nominal();
    t_window_edge();
    t_multi_loss();
    t_resync();
    t_bus_reset();
    idle(5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule